// File: doc/BRIEF.md
# Dual-Bridge Phase-Shift PWM Generator

This block drives the gates of two bridges, a primary and a secondary, with square waves that always hold a 50% duty cycle. A signed fixed-point modulation value sets the phase between the two. A value of -1 gives a shift of -180 degrees and +1 gives +180 degrees, and the mapping is linear in between. A free-running counter supplies the turn-on carrier. The turn-off carrier is the same count offset by half a period. Each bridge has its own compare value. Both compare values are mirrored about mid-scale. A crossing of the turn-on carrier sets a leg, and a crossing of the turn-off carrier clears it.

The sequencer has two states. In `SEQ_IDLE` the counter is held at zero and both gates are low. The transition IDLE->RUN is taken when `en` is sampled high. In `SEQ_RUN` the counter advances by one every cycle. The transition RUN->IDLE is taken when `en` is sampled low. Each leg also has two states, `GATE_LOW` and `GATE_HIGH`:
- LOW->HIGH happens on a turn-on crossing, provided no turn-off crossing occurs in the same cycle, because clear wins.
- HIGH->LOW happens on a turn-off crossing, or whenever the sequencer is not running.

The modulation input is sampled in the cycle just before each period begins, so a change never takes effect in the middle of a period.

Top module: `dab_phase_pwm`

## Requirements
- R1: While enabled, the counter runs through Q = 2^CNT_W positions, and a period is exactly Q cycles long. The position is 0 in the cycle that `period_start` is high and rises by one each cycle.
- R2: `period_start` is high for exactly one cycle at position 0 of every period. This includes the first period, whose position 0 is the cycle right after the edge that samples `en` high while idle.
- R3: With H = Q/2 and offset = floor(m_sat * 2^(CNT_W-2) / 2^15), the primary compare value is H - offset and the secondary compare value is H + offset. Each gate goes high at position (compare + 1) and goes low at position ((compare + H) mod Q) + 1.
- R4: The modulation input is signed with 15 fraction bits, so 32768 means +1.0. Values above 32768 act as 32768, and values below -32768 act as -32768.
- R5: Under a steady modulation value, each gate is high for exactly H cycles in every period.
- R6: The secondary gate rises (2*offset) mod Q cycles after the primary gate. At m = 0 both gates rise in the same cycle. At m = +1 the secondary rises H cycles after the primary, which is 180 degrees.
- R7: `mod_in` is sampled only in the cycle before position 0. A change made during a period does not alter that period's gate edges.
- R8: While reset is asserted, and until the first enabled period, both gates and `period_start` are low.
- R9: One cycle after `en` is sampled low, both gates and `period_start` are low, and the counter restarts. When `en` is raised again, a new period begins, with `period_start` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; low forces both gates low |
| mod_in | input | MOD_W | Signed modulation value, 15 fraction bits |
| gate_pri | output | 1 | Primary bridge gate |
| gate_sec | output | 1 | Secondary bridge gate |
| period_start | output | 1 | High in the first cycle of each carrier period |

## Verification
Three timings govern when each result is due:
- A gate edge appears one cycle after the counter reaches the crossing position.
- `period_start` appears one cycle after the edge that sees full scale, or that sees `en` rise.
- A new modulation value shows up in the period that follows the sampling cycle, and it is only fully settled one period after that.

The bench samples outputs on the falling edge. It compares every cycle against a bench model that applies the same register delays. Its directed checks of duty and edge position wait three full periods after each change of modulation, so that only steady-state periods are measured.

// File: rtl/dab_pwm_pkg.sv
package dab_pwm_pkg;
    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    typedef enum logic {
        GATE_LOW  = 1'b0,
        GATE_HIGH = 1'b1
    } gate_state_e;

    localparam int NUM_LEGS = 2;
    localparam int LEG_PRI  = 0;
    localparam int LEG_SEC  = 1;
endpackage

// File: rtl/dab_pwm_carrier.sv
module dab_pwm_carrier
    import dab_pwm_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] prev_o,
    output logic             active_o,
    output logic             load_o,
    output logic             strobe_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = 1;

    seq_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, prev_q;
    logic             strobe_q;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= SEQ_IDLE;
        else     state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE: state_d = en ? SEQ_RUN : SEQ_IDLE;
            SEQ_RUN:  state_d = en ? SEQ_RUN : SEQ_IDLE;
        endcase
    end

    // outputs of the sequencer
    always_comb begin
        active_o = 1'b0;
        load_o   = 1'b0;
        unique case (state_q)
            SEQ_IDLE: load_o = en;
            SEQ_RUN: begin
                active_o = en;
                load_o   = en && (cnt_q == CNT_MAX);
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            prev_q   <= '0;
            strobe_q <= 1'b0;
        end else begin
            strobe_q <= load_o;
            if (active_o) begin
                cnt_q  <= cnt_q + CNT_ONE;
                prev_q <= cnt_q;
            end else begin
                cnt_q  <= '0;
                prev_q <= '0;
            end
        end
    end

    assign cnt_o    = cnt_q;
    assign prev_o   = prev_q;
    assign strobe_o = strobe_q;

    assert_strobe_at_zero_R2: assert property (@(posedge clk) disable iff (rst)
        strobe_q |-> cnt_q == '0);

    assert_count_step_R1: assert property (@(posedge clk) disable iff (rst)
        $past(active_o) |-> cnt_q == $past(cnt_q) + CNT_ONE);
endmodule

// File: rtl/dab_pwm_modmap.sv
module dab_pwm_modmap
    import dab_pwm_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int MOD_W  = 18,
    parameter int FRAC_W = 15
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                load_i,
    input  logic signed [MOD_W-1:0]             mod_i,
    output logic [NUM_LEGS-1:0][CNT_W-1:0]      cmp_o
);
    localparam int PW = MOD_W + CNT_W;
    localparam logic signed [MOD_W-1:0] MOD_POS = MOD_W'(2**FRAC_W);
    localparam logic signed [MOD_W-1:0] MOD_NEG = -MOD_POS;
    localparam logic signed [PW-1:0]    HALF_S  = PW'(2**(CNT_W-1));
    localparam logic [CNT_W-1:0]        CMP_MID = CNT_W'(2**(CNT_W-1));
    localparam logic [CNT_W-1:0]        CMP_LO  = CNT_W'(2**(CNT_W-2));
    localparam logic [CNT_W-1:0]        CMP_HI  = CNT_W'(3 * 2**(CNT_W-2));
    localparam logic [CNT_W:0]          CMP_SUM = (CNT_W+1)'(2**CNT_W);

    logic signed [MOD_W-1:0]          mod_sat;
    logic signed [PW-1:0]             mod_ext, offs;
    logic [NUM_LEGS-1:0][CNT_W-1:0]   cmp_d, cmp_q;

    always_comb begin
        if (mod_i > MOD_POS)      mod_sat = MOD_POS;
        else if (mod_i < MOD_NEG) mod_sat = MOD_NEG;
        else                      mod_sat = mod_i;
        mod_ext = PW'(mod_sat);
        offs    = (mod_ext <<< (CNT_W - 2)) >>> FRAC_W;
    end

    for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg_cmp
        if (g == LEG_PRI) begin : g_minus
            assign cmp_d[g] = CNT_W'(HALF_S - offs);
        end else begin : g_plus
            assign cmp_d[g] = CNT_W'(HALF_S + offs);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_LEGS; i++) cmp_q[i] <= CMP_MID;
        end else if (load_i) begin
            cmp_q <= cmp_d;
        end
    end

    assign cmp_o = cmp_q;

    assert_mirror_R3: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, cmp_q[LEG_PRI]} + {1'b0, cmp_q[LEG_SEC]}) == CMP_SUM);

    assert_cmp_range_R4: assert property (@(posedge clk) disable iff (rst)
        cmp_q[LEG_PRI] >= CMP_LO && cmp_q[LEG_PRI] <= CMP_HI);

    assert_cmp_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !$past(load_i) |-> $stable(cmp_q));
endmodule

// File: rtl/dab_pwm_gate.sv
module dab_pwm_gate
    import dab_pwm_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             active_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] prev_i,
    input  logic [CNT_W-1:0] cmp_i,
    output logic             gate_o
);
    localparam logic [CNT_W-1:0] HALF_V = CNT_W'(2**(CNT_W-1));

    gate_state_e      state_q, state_d;
    logic [CNT_W-1:0] off_cur, off_prev;
    logic             set_evt, clr_evt;

    // turn-on carrier is the count; turn-off carrier is shifted by half scale
    always_comb begin
        off_cur  = cnt_i + HALF_V;
        off_prev = prev_i + HALF_V;
        set_evt  = active_i && (prev_i < cmp_i) && (cnt_i >= cmp_i);
        clr_evt  = active_i && (off_prev < cmp_i) && (off_cur >= cmp_i);
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= GATE_LOW;
        else     state_q <= state_d;
    end

    // next state, clear wins over set
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GATE_LOW:  if (set_evt && !clr_evt) state_d = GATE_HIGH;
            GATE_HIGH: if (!active_i || clr_evt) state_d = GATE_LOW;
        endcase
    end

    // output
    always_comb begin
        gate_o = 1'b0;
        unique case (state_q)
            GATE_LOW:  gate_o = 1'b0;
            GATE_HIGH: gate_o = 1'b1;
        endcase
    end

    assert_gate_low_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !active_i |=> state_q == GATE_LOW);

    assert_rise_at_cmp_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(gate_o) |-> $past(cnt_i) == $past(cmp_i));

    assert_fall_at_cmp_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(gate_o) && $past(active_i) |-> $past(cnt_i) + HALF_V == $past(cmp_i));
endmodule

// File: rtl/dab_phase_pwm.sv
module dab_phase_pwm
    import dab_pwm_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int MOD_W  = 18,
    parameter int FRAC_W = 15
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en,
    input  logic signed [MOD_W-1:0] mod_in,
    output logic                    gate_pri,
    output logic                    gate_sec,
    output logic                    period_start
);
    logic [CNT_W-1:0]               cnt_w, prev_w;
    logic                           active_w, load_w;
    logic [NUM_LEGS-1:0][CNT_W-1:0] cmp_w;
    logic [NUM_LEGS-1:0]            gate_w;

    dab_pwm_carrier #(.CNT_W(CNT_W)) u_carrier (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .cnt_o    (cnt_w),
        .prev_o   (prev_w),
        .active_o (active_w),
        .load_o   (load_w),
        .strobe_o (period_start)
    );

    dab_pwm_modmap #(.CNT_W(CNT_W), .MOD_W(MOD_W), .FRAC_W(FRAC_W)) u_modmap (
        .clk    (clk),
        .rst    (rst),
        .load_i (load_w),
        .mod_i  (mod_in),
        .cmp_o  (cmp_w)
    );

    for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
        dab_pwm_gate #(.CNT_W(CNT_W)) u_gate (
            .clk      (clk),
            .rst      (rst),
            .active_i (active_w),
            .cnt_i    (cnt_w),
            .prev_i   (prev_w),
            .cmp_i    (cmp_w[g]),
            .gate_o   (gate_w[g])
        );
    end

    assign gate_pri = gate_w[LEG_PRI];
    assign gate_sec = gate_w[LEG_SEC];

    assert_strobe_single_R2: assert property (@(posedge clk) disable iff (rst)
        period_start |=> !period_start);
endmodule

// File: tb/dab_phase_pwm_test.sv
module dab_phase_pwm_test;
    localparam int CNT_W = 8;
    localparam int MOD_W = 18;
    localparam int Q     = 1 << CNT_W;
    localparam int H     = Q / 2;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic                    en  = 1'b0;
    logic signed [MOD_W-1:0] mod_in = '0;
    logic                    gate_pri, gate_sec, period_start;

    int    n_cmp = 0, n_bad = 0, cycles = 0;
    bit    chk_on = 1'b0;
    string cur_tag = "R8";

    dab_phase_pwm #(.CNT_W(CNT_W), .MOD_W(MOD_W), .FRAC_W(15)) uut (
        .clk(clk), .rst(rst), .en(en), .mod_in(mod_in),
        .gate_pri(gate_pri), .gate_sec(gate_sec), .period_start(period_start)
    );

    always #4 clk = ~clk;

    function automatic int exp_offset(input int m);
        int s = m;
        if (s > 32768) s = 32768;
        if (s < -32768) s = -32768;
        return (s * (1 << (CNT_W - 2))) >>> 15;
    endfunction

    function automatic bit next_gate(input bit act, input int c, input int cmp, input bit g);
        if (!act) return 1'b0;
        if (c == (cmp + H) % Q) return 1'b0;
        if (c == cmp) return 1'b1;
        return g;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    // bench model of the requirements, updated at the same edges as the design
    bit m_run, m_gp, m_gs, m_stb;
    int m_cnt, m_cp = H, m_cs = H;
    always @(posedge clk) begin
        if (rst) begin
            m_run <= 0; m_cnt <= 0; m_cp <= H; m_cs <= H;
            m_gp <= 0; m_gs <= 0; m_stb <= 0;
        end else begin
            m_stb <= en && (!m_run || m_cnt == Q - 1);
            if (en && (!m_run || m_cnt == Q - 1)) begin
                m_cp <= H - exp_offset(int'(mod_in));
                m_cs <= H + exp_offset(int'(mod_in));
            end
            m_cnt <= (m_run && en) ? (m_cnt + 1) % Q : 0;
            m_gp  <= next_gate(m_run && en, m_cnt, m_cp, m_gp);
            m_gs  <= next_gate(m_run && en, m_cnt, m_cs, m_gs);
            m_run <= en;
        end
    end

    // per-cycle comparison and period measurement
    int pos = 0, hp = 0, hs = 0, rp = -1, rs = -1;
    int last_len = 0, last_hp = 0, last_hs = 0, last_rp = -1, last_rs = -1;
    bit pgp = 0, pgs = 0;
    always @(negedge clk) begin
        if (chk_on) begin
            check(gate_pri == m_gp, {cur_tag, " R3 primary gate per cycle"}, gate_pri, m_gp);
            check(gate_sec == m_gs, {cur_tag, " R6 secondary gate per cycle"}, gate_sec, m_gs);
            check(period_start == m_stb, {cur_tag, " R2 period_start per cycle"}, period_start, m_stb);
        end
        if (period_start) begin
            last_len = pos + 1; last_hp = hp; last_hs = hs; last_rp = rp; last_rs = rs;
            pos = 0; hp = int'(gate_pri); hs = int'(gate_sec);
            rp = (gate_pri && !pgp) ? 0 : -1;
            rs = (gate_sec && !pgs) ? 0 : -1;
        end else begin
            pos++; hp += int'(gate_pri); hs += int'(gate_sec);
            if (gate_pri && !pgp) rp = pos;
            if (gate_sec && !pgs) rs = pos;
        end
        pgp = gate_pri; pgs = gate_sec;
    end

    task automatic settle_and_check(input int m, input string tag);
        int off, cp, cs;
        mod_in  = MOD_W'(m);
        cur_tag = tag;
        repeat (3 * Q) @(negedge clk);
        #1;
        off = exp_offset(m); cp = H - off; cs = H + off;
        check(last_len == Q, {tag, " R1 period length"}, last_len, Q);
        check(last_hp == H, {tag, " R5 primary high cycles"}, last_hp, H);
        check(last_hs == H, {tag, " R5 secondary high cycles"}, last_hs, H);
        check(last_rp == cp + 1, {tag, " R3 primary rise position"}, last_rp, cp + 1);
        check(last_rs == cs + 1, {tag, " R3 secondary rise position"}, last_rs, cs + 1);
        check(((last_rs - last_rp) % Q + Q) % Q == ((2 * off) % Q + Q) % Q,
              {tag, " R6 phase lag"}, ((last_rs - last_rp) % Q + Q) % Q, ((2 * off) % Q + Q) % Q);
    endtask

    task automatic wait_strobe();
        for (int i = 0; i < 2 * Q; i++) begin
            @(negedge clk);
            if (period_start) break;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got %0d cycles expected below %0d", cycles, 150000);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5171));
        repeat (3) @(negedge clk);
        chk_on = 1'b1;
        check(gate_pri == 0, "R8 primary low in reset", gate_pri, 0);
        check(gate_sec == 0, "R8 secondary low in reset", gate_sec, 0);
        check(period_start == 0, "R8 strobe low in reset", period_start, 0);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        check(gate_pri == 0 && period_start == 0, "R8 outputs low while disabled", gate_pri, 0);

        en = 1'b1;
        @(negedge clk);
        check(period_start == 1, "R2 first strobe after enable", period_start, 1);

        settle_and_check(0, "R6 zero");
        settle_and_check(32768, "R6 plus one");
        settle_and_check(-32768, "R6 minus one");
        settle_and_check(100000, "R4 high clamp");
        settle_and_check(-120000, "R4 low clamp");
        settle_and_check(-1, "R3 floor");
        settle_and_check(16384, "R3 quarter");

        // R7: mid-period change does not affect the current period
        settle_and_check(0, "R7 base");
        wait_strobe();
        repeat (10) @(negedge clk);
        mod_in = MOD_W'(32768);
        wait_strobe();
        #1;
        check(last_rp == H + 1, "R7 primary rise keeps old value", last_rp, H + 1);
        check(last_rs == H + 1, "R7 secondary rise keeps old value", last_rs, H + 1);
        settle_and_check(32768, "R7 applied");

        // R9: disable while a gate is high
        for (int i = 0; i < 2 * Q; i++) begin
            @(negedge clk);
            if (gate_pri) break;
        end
        cur_tag = "R9";
        en = 1'b0;
        @(negedge clk);
        check(gate_pri == 0, "R9 primary low after disable", gate_pri, 0);
        check(gate_sec == 0, "R9 secondary low after disable", gate_sec, 0);
        check(period_start == 0, "R9 strobe low after disable", period_start, 0);
        repeat (4) @(negedge clk);
        en = 1'b1;
        @(negedge clk);
        check(period_start == 1, "R9 strobe after re-enable", period_start, 1);
        settle_and_check(-16384, "R9 restart");

        for (int k = 0; k < 8; k++) begin
            int r;
            r = int'($urandom % 80001) - 40000;
            settle_and_check(r, "R3 random");
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule